// File: doc/BRIEF.md
# Flash Range Erase Sequencer

This block turns a request to erase a run of 4 KB sectors on a serial NOR flash into a series of byte-level SPI frames. Each request gives a first sector index and a sector count. The block walks the range and, at each step, issues the largest erase the current position allows. It uses a 64 KB erase when the index sits on a 16-sector boundary and at least 16 sectors remain. It uses a 32 KB erase when the index sits on an 8-sector boundary and at least 8 sectors remain. In every other case it uses a single 4 KB sector erase.

Before every erase, the block polls the flash status register until the flash is no longer busy. It then sends a write-enable in a frame of its own, and finally sends the erase frame. While the flash reports busy, the chip select is released for a programmable idle gap before the next poll, so the bus is not held during long erases. A separate request flag asks for a whole-chip erase, which waits for the flash to go idle again before acknowledging. The SPI side is a simple byte shifter handshake: the block asks for one byte at a time, holds the chip select for the length of each frame, and gets each received byte back with a done strobe.

Top module: `flash_erase_seq`

## Requirements
- R1: A 64 KB block erase (first frame byte 0xD8) is issued when the current sector index is a multiple of 16 and at least 16 sectors remain; the index then advances by 16.
- R2: When the 64 KB rule does not apply, a 32 KB block erase (first byte 0x52) is issued if the index is a multiple of 8 and at least 8 sectors remain; the index then advances by 8.
- R3: When neither larger erase applies, a 4 KB sector erase (first byte 0x20) is issued and the index advances by 1.
- R4: Every erase is preceded by one or more two-byte status frames (0x05 followed by one dummy byte 0x00). Bit 0 of the byte received in the second byte slot is the busy flag, and the polls repeat until that bit reads 0. Exactly one byte request is outstanding at a time.
- R5: After the last idle status poll, the byte 0x06 is sent alone in its own chip-select frame, directly before the erase frame.
- R6: An erase frame is four bytes long: the opcode, then the byte address (sector index times 4096) in three bytes, most significant byte first.
- R7: A request with the chip flag set sends status polls, the write-enable frame and then the single byte 0xC7 with no address. It then polls status again until idle before it acknowledges. The start and count inputs are not used for such a request.
- R8: Consecutive frames within a request are separated by exactly one deselected cycle. After a poll that read busy, chip select instead stays low for exactly gap_cycles + 2 cycles.
- R9: req_ack is a one-cycle pulse with chip select low. It comes one cycle after the last frame of the request ends. A sector request with a count of zero acknowledges without any SPI frame.
- R10: req_valid is ignored while a request is in progress; the frame sequence of the running request is unchanged.
- R11: During and directly after reset, spi_sel, spi_start and req_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a request (sampled only while idle) |
| req_chip | input | 1 | 1 = whole-chip erase, 0 = sector range erase |
| req_start | input | SECT_W | First 4 KB sector index |
| req_count | input | CNT_W | Number of 4 KB sectors to erase |
| gap_cycles | input | GAP_W | Idle cycles added between busy polls |
| req_ack | output | 1 | One-cycle completion pulse |
| spi_sel | output | 1 | Chip select, high while a frame is active |
| spi_start | output | 1 | Request the shifter to transfer spi_tx |
| spi_tx | output | 8 | Byte to transmit |
| spi_done | input | 1 | Shifter finished the requested byte |
| spi_rx | input | 8 | Byte received during that transfer |

## Verification
The assertions assume that the shifter raises spi_done only while a byte is outstanding, and no earlier than the cycle after spi_start. They also assume that a range request never runs past the last sector index. Inputs are assumed to stay stable while the block samples them. The bench flash model answers each byte after a random latency of one to three cycles and fills the upper status bits with random values. It keeps every range inside the device, holds gap_cycles constant for the duration of each request, and issues only one stray req_valid pulse, and only while a request is known to be running.

// File: rtl/fes_pkg.sv
package fes_pkg;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_ER64   = 8'hD8;
    localparam logic [7:0] OP_ER32   = 8'h52;
    localparam logic [7:0] OP_ER4    = 8'h20;
    localparam logic [7:0] OP_CHIP   = 8'hC7;
    localparam logic [7:0] FILL_BYTE = 8'h00;

    localparam int unsigned SPAN_BIG = 16;
    localparam int unsigned SPAN_MID = 8;
    localparam int unsigned SECTOR_SHIFT = 12;
    localparam int unsigned ADDR_W = 24;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_WAIT, ST_DESEL, ST_GAP, ST_ACK
    } seq_state_e;

    typedef enum logic [1:0] {
        FR_STATUS, FR_WREN, FR_ERASE
    } frame_e;
endpackage

// File: rtl/erase_step_sel.sv
module erase_step_sel
    import fes_pkg::*;
#(
    parameter int SECT_W = 12,
    parameter int CNT_W  = 13
) (
    input  logic [SECT_W-1:0] idx,
    input  logic [CNT_W-1:0]  rem,
    output logic [7:0]        opcode,
    output logic [CNT_W-1:0]  step
);
    localparam logic [SECT_W-1:0] BIG_MASK = SECT_W'(SPAN_BIG - 1);
    localparam logic [SECT_W-1:0] MID_MASK = SECT_W'(SPAN_MID - 1);

    logic big_ok, mid_ok;

    always_comb begin
        big_ok = ((idx & BIG_MASK) == '0) && (rem >= CNT_W'(SPAN_BIG));
        mid_ok = ((idx & MID_MASK) == '0) && (rem >= CNT_W'(SPAN_MID));
        if (big_ok) begin
            opcode = OP_ER64;
            step   = CNT_W'(SPAN_BIG);
        end else if (mid_ok) begin
            opcode = OP_ER32;
            step   = CNT_W'(SPAN_MID);
        end else begin
            opcode = OP_ER4;
            step   = CNT_W'(1);
        end
    end
endmodule

// File: rtl/frame_byte_gen.sv
module frame_byte_gen
    import fes_pkg::*;
#(
    parameter int SECT_W = 12
) (
    input  frame_e            frame,
    input  logic [1:0]        bidx,
    input  logic              chip,
    input  logic [7:0]        erase_op,
    input  logic [SECT_W-1:0] idx,
    output logic [7:0]        tx_byte,
    output logic              last_byte
);
    logic [ADDR_W-1:0] addr;

    always_comb begin
        addr      = ADDR_W'(idx) << SECTOR_SHIFT;
        tx_byte   = FILL_BYTE;
        last_byte = 1'b1;
        case (frame)
            FR_STATUS: begin
                tx_byte   = (bidx == 2'd0) ? OP_STATUS : FILL_BYTE;
                last_byte = (bidx == 2'd1);
            end
            FR_WREN: begin
                tx_byte   = OP_WREN;
                last_byte = 1'b1;
            end
            default: begin
                if (chip) begin
                    tx_byte   = OP_CHIP;
                    last_byte = 1'b1;
                end else begin
                    case (bidx)
                        2'd0:    tx_byte = erase_op;
                        2'd1:    tx_byte = addr[23:16];
                        2'd2:    tx_byte = addr[15:8];
                        default: tx_byte = addr[7:0];
                    endcase
                    last_byte = (bidx == 2'd3);
                end
            end
        endcase
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int SECT_W = 12,
    parameter int CNT_W  = 13,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_chip,
    input  logic [SECT_W-1:0] req_start,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [GAP_W-1:0]  gap_cycles,
    output logic              req_ack,
    output logic              spi_sel,
    output logic              spi_start,
    output logic [7:0]        spi_tx,
    input  logic              spi_done,
    input  logic [7:0]        spi_rx
);
    typedef struct packed {
        seq_state_e        st;
        frame_e            frame;
        logic [1:0]        bidx;
        logic [SECT_W-1:0] idx;
        logic [CNT_W-1:0]  rem;
        logic              chip;
        logic              fin;
        logic              busy;
        logic [GAP_W-1:0]  gap;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [7:0]       erase_op;
    logic [CNT_W-1:0] step;
    logic [7:0]       tx_byte;
    logic             last_byte;

    erase_step_sel #(.SECT_W(SECT_W), .CNT_W(CNT_W)) step_i (
        .idx    (r_q.idx),
        .rem    (r_q.rem),
        .opcode (erase_op),
        .step   (step)
    );

    frame_byte_gen #(.SECT_W(SECT_W)) bytes_i (
        .frame     (r_q.frame),
        .bidx      (r_q.bidx),
        .chip      (r_q.chip),
        .erase_op  (erase_op),
        .idx       (r_q.idx),
        .tx_byte   (tx_byte),
        .last_byte (last_byte)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.idx   = req_start;
                    r_d.rem   = req_count;
                    r_d.chip  = req_chip;
                    r_d.fin   = 1'b0;
                    r_d.frame = FR_STATUS;
                    r_d.bidx  = 2'd0;
                    r_d.st    = (!req_chip && req_count == '0) ? ST_ACK : ST_SEND;
                end
            end
            ST_SEND: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (spi_done) begin
                    if (r_q.frame == FR_STATUS && r_q.bidx == 2'd1) r_d.busy = spi_rx[0];
                    if (last_byte) begin
                        r_d.st = ST_DESEL;
                    end else begin
                        r_d.bidx = r_q.bidx + 2'd1;
                        r_d.st   = ST_SEND;
                    end
                end
            end
            ST_DESEL: begin
                r_d.bidx = 2'd0;
                r_d.st   = ST_SEND;
                case (r_q.frame)
                    FR_STATUS: begin
                        if (r_q.busy) begin
                            r_d.st  = ST_GAP;
                            r_d.gap = gap_cycles;
                        end else if (r_q.fin) begin
                            r_d.st = ST_ACK;
                        end else begin
                            r_d.frame = FR_WREN;
                        end
                    end
                    FR_WREN: r_d.frame = FR_ERASE;
                    default: begin
                        r_d.frame = FR_STATUS;
                        if (r_q.chip) begin
                            r_d.fin = 1'b1;
                        end else begin
                            r_d.idx = r_q.idx + SECT_W'(step);
                            r_d.rem = r_q.rem - step;
                            if (r_q.rem == step) r_d.st = ST_ACK;
                        end
                    end
                endcase
            end
            ST_GAP: begin
                if (r_q.gap == '0) r_d.st = ST_SEND;
                else               r_d.gap = r_q.gap - 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, frame: FR_STATUS, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_sel   = (r_q.st == ST_SEND) || (r_q.st == ST_WAIT);
    assign spi_start = (r_q.st == ST_SEND);
    assign spi_tx    = tx_byte;
    assign req_ack   = (r_q.st == ST_ACK);

    p_start_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |-> spi_sel);
    p_single_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |=> !spi_start);
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    p_ack_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !spi_sel);
    p_big_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_start && r_q.frame == FR_ERASE && r_q.bidx == 2'd0 && spi_tx == OP_ER64)
        |-> (r_q.idx[3:0] == 4'd0 && r_q.rem >= CNT_W'(SPAN_BIG)));
    p_mid_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_start && r_q.frame == FR_ERASE && r_q.bidx == 2'd0 && spi_tx == OP_ER32)
        |-> (r_q.idx[2:0] == 3'd0 && r_q.rem >= CNT_W'(SPAN_MID)));
    p_step_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DESEL && r_q.frame == FR_ERASE && !r_q.chip) |-> (step <= r_q.rem));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (!spi_sel && !req_ack));
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
    localparam int SECT_W = 12;
    localparam int CNT_W  = 13;
    localparam int GAP_W  = 8;
    localparam int NSECT  = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_chip = 1'b0;
    logic [SECT_W-1:0] req_start = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic [GAP_W-1:0]  gap_cycles = '0;
    logic req_ack, spi_sel, spi_start;
    logic [7:0] spi_tx;
    logic spi_done = 1'b0;
    logic [7:0] spi_rx = 8'h00;

    always #10 clk = ~clk;

    flash_erase_seq #(.SECT_W(SECT_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chip(req_chip),
        .req_start(req_start), .req_count(req_count), .gap_cycles(gap_cycles),
        .req_ack(req_ack), .spi_sel(spi_sel), .spi_start(spi_start), .spi_tx(spi_tx),
        .spi_done(spi_done), .spi_rx(spi_rx)
    );

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] exp_word[$];
    int          exp_len[$];
    int          busy_plan[$];

    logic [31:0] cur_word = '0;
    int cur_len = 0;
    int lat_cnt = 0;
    logic [7:0] pend_rx = '0;
    int cur_busy = -1;
    bit last_poll_busy = 0;
    bit sel_prev = 0;
    int low_run = 0;
    bit in_req = 0;
    int frames_in_req = 0;
    int acks = 0;

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h05: return "R4";
            8'h06: return "R5";
            8'hD8: return "R1 R6";
            8'h52: return "R2 R6";
            8'h20: return "R3 R6";
            8'hC7: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic push_frame(input logic [31:0] w, input int len);
        exp_word.push_back(w);
        exp_len.push_back(len);
    endtask

    task automatic push_polls(input int b);
        busy_plan.push_back(b);
        for (int i = 0; i <= b; i++) push_frame(32'h0000_0500, 2);
    endtask

    // Reference plan from R1..R6: greedy choice, polls, write enable, erase frame.
    task automatic plan_range(input int st, input int cnt);
        int idx = st;
        int rem = cnt;
        while (rem > 0) begin
            logic [7:0] op;
            int span;
            logic [23:0] a;
            if (idx % 16 == 0 && rem >= 16) begin op = 8'hD8; span = 16; end
            else if (idx % 8 == 0 && rem >= 8) begin op = 8'h52; span = 8; end
            else begin op = 8'h20; span = 1; end
            a = 24'(idx * 4096);
            push_polls($urandom % 3);
            push_frame(32'h0000_0006, 1);
            push_frame({op, a}, 4);
            idx += span;
            rem -= span;
        end
    endtask

    task automatic plan_chip();
        push_polls($urandom % 3);
        push_frame(32'h0000_0006, 1);
        push_frame(32'h0000_00C7, 1);
        push_polls($urandom % 3);
    endtask

    // Flash model and frame monitor, all on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            check(!spi_sel && !spi_start && !req_ack, "R11", "outputs in reset",
                  {29'd0, spi_sel, spi_start, req_ack}, 32'd0);
            sel_prev = 0;
            spi_done = 0;
        end else begin
            spi_done = 0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    spi_done = 1;
                    spi_rx   = pend_rx;
                end
            end
            if (sel_prev && !spi_sel) begin
                if (exp_word.size() == 0) begin
                    check(0, "R10", "unexpected frame", cur_word, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ew;
                    int el;
                    ew = exp_word.pop_front();
                    el = exp_len.pop_front();
                    check(ew == cur_word && el == cur_len, tag_of(el == 2 ? ew[15:8] : ew[31:24] & {8{el == 4}} | ew[7:0] & {8{el == 1}}),
                          "frame bytes", cur_word, ew);
                end
                frames_in_req++;
                cur_word = '0;
                cur_len  = 0;
                low_run  = 1;
            end else if (!spi_sel) begin
                low_run++;
            end
            if (!sel_prev && spi_sel && in_req && frames_in_req > 0) begin
                int exp_gap;
                exp_gap = last_poll_busy ? int'(gap_cycles) + 2 : 1;
                check(low_run == exp_gap, "R8", "deselect run", low_run, exp_gap);
            end
            if (spi_start) begin
                check(spi_sel, "R4", "start outside frame", 0, 1);
                cur_word = {cur_word[23:0], spi_tx};
                cur_len++;
                pend_rx = $urandom;
                if (cur_len == 2 && cur_word[15:8] == 8'h05) begin
                    if (cur_busy < 0) cur_busy = (busy_plan.size() > 0) ? busy_plan.pop_front() : 0;
                    pend_rx = {pend_rx[7:1], 1'b0};
                    if (cur_busy > 0) begin
                        pend_rx[0] = 1'b1;
                        cur_busy--;
                        last_poll_busy = 1;
                    end else begin
                        cur_busy = -1;
                        last_poll_busy = 0;
                    end
                end
                lat_cnt = 1 + ($urandom % 3);
            end
            if (req_ack) begin
                acks++;
                check(!spi_sel, "R9", "select low at ack", 32'(spi_sel), 0);
                check(exp_word.size() == 0, "R9", "frames left at ack", exp_word.size(), 0);
                if (frames_in_req > 0)
                    check(low_run == 2, "R9", "ack latency after last frame", low_run, 2);
                in_req = 0;
            end
            sel_prev = spi_sel;
        end
    end

    task automatic run(input bit chip, input int st, input int cnt, input int gap, input bit poke);
        int waited = 0;
        if (chip) plan_chip(); else plan_range(st, cnt);
        gap_cycles = GAP_W'(gap);
        @(negedge clk);
        in_req = 1;
        frames_in_req = 0;
        acks = 0;
        req_valid = 1;
        req_chip  = chip;
        req_start = SECT_W'(st);
        req_count = CNT_W'(cnt);
        @(negedge clk);
        req_valid = 0;
        while (acks == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 15) begin
                req_valid = 1; req_chip = 1; req_start = 12'h00F; req_count = 13'd3;
            end else begin
                req_valid = 0;
            end
        end
        req_valid = 0;
        check(waited < 20000, "R9", "acknowledge timeout", waited, 20000);
        repeat (3) @(negedge clk);
        check(acks == 1, poke ? "R10" : "R9", "ack count", acks, 1);
        if (!chip && cnt == 0)
            check(frames_in_req == 0, "R9", "zero count frames", frames_in_req, 0);
        exp_word.delete(); exp_len.delete(); busy_plan.delete();
        cur_busy = -1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run(0, 0, 0, 0, 0);        // R9 count zero
        run(0, 0, 16, 2, 0);       // R1 single 64 KB
        run(0, 8, 8, 0, 0);        // R2 single 32 KB
        run(0, 3, 30, 3, 1);       // R3 mixed run, R10 stray request
        run(0, 4095, 1, 1, 0);     // R6 top sector address
        run(0, 24, 9, 0, 0);       // R2 then R3
        run(1, 0, 0, 4, 0);        // R7 chip erase
        for (int k = 0; k < 14; k++) begin
            int st, cnt;
            st  = $urandom % NSECT;
            cnt = 1 + ($urandom % 40);
            if (st + cnt > NSECT) cnt = NSECT - st;
            run(0, st, cnt, $urandom % 6, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule